// File: doc/BRIEF.md
# Vector Length Setting Unit

This unit carries out the set-vector-length management operation of a scalable vector pipeline. It takes the operation's decoded fields in one cycle: a 7-bit length immediate, the flags that ask for a new maximum length, a new length, and vertical-first mode, the two register field numbers (source and target), and the record bit. It also takes the source register value, the count register value and the current 64-bit loop-state word. One cycle later it presents the new loop-state word with the maximum length (MVL) and vector length (VL) fields replaced. When the target field is nonzero it also presents a register write of VL, and when the record bit is set it presents a condition nibble.

VL comes from one of three places. A nonzero source field selects the source register. A zero source field with a zero target field selects the immediate. Otherwise VL comes from the count register. A register or count value that does not fit in 7 bits saturates. The chosen length is then limited to MVL. Either event sets the overflow bit of the condition nibble.

Control is a two-state machine. ST_IDLE holds every write enable low. ST_RESP presents one result. The transitions are accept (ST_IDLE to ST_RESP on `in_valid`), chain (ST_RESP stays in ST_RESP on a new `in_valid`) and retire (ST_RESP to ST_IDLE without one). Operands are captured on every accepted operation, so back-to-back operations give one result per cycle.

Top module: `vlen_set_unit`

## Requirements
- R1: The immediate stands for one less than the intended length; the unit adds one and keeps the low 7 bits. With `set_mvl`=1 the new MVL is that value (an immediate of 127 yields MVL 0); with `set_mvl`=0 MVL keeps its value from `state_in`.
- R2: With `set_vl`=0 the candidate VL is the current VL from `state_in`.
- R3: With `set_vl`=1 the candidate VL is chosen as follows. If `ra_num` is nonzero, it is `ra_val`. Otherwise, if `rt_num` is zero, it is the incremented immediate. Otherwise it is `ctr_val`.
- R4: A register or count candidate above 127 becomes 127 and sets overflow; the immediate path never sets overflow by itself.
- R5: A candidate VL greater than the new MVL is replaced by MVL and sets overflow. This applies to every path, including the held VL of R2.
- R6: When `rt_num` is nonzero, `gpr_we` is 1, `gpr_num` equals `rt_num` and `gpr_data` is the final VL zero-extended to 64 bits. When `rt_num` is zero, `gpr_we` stays 0.
- R7: Only with `set_mvl`=1 are the mode bits rewritten: `state_out[0]` (vertical-first) takes `vf_bit` and `state_out[1]` (remap persistence) is cleared. Otherwise both keep their `state_in` values.
- R8: With `rc`=1, `cr_we` is 1 and `cr0` is {bit3 LT=0, bit2 GT = (VL != 0), bit1 EQ = (VL == 0), bit0 SO = overflow}. With `rc`=0, `cr_we` stays 0.
- R9: In `state_out`, MVL is `[63:57]` and VL is `[56:50]`, the most significant state bit being bit 63. Every other bit except those of R7 equals `state_in`.
- R10: All results and enables appear in the cycle after `in_valid` is sampled high. `state_we` is 1 exactly then, and all enables are 0 in reset and in any cycle that follows one without `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| imm | input | 7 | Length immediate, encoded minus one |
| set_mvl | input | 1 | Request new maximum length (and mode bits) |
| set_vl | input | 1 | Request new vector length |
| vf_bit | input | 1 | Vertical-first mode value |
| ra_num | input | 5 | Source register field number |
| rt_num | input | 5 | Target register field number |
| rc | input | 1 | Record condition nibble |
| ra_val | input | 64 | Source register value |
| ctr_val | input | 64 | Count register value |
| state_in | input | 64 | Current loop-state word |
| state_we | output | 1 | Loop-state write enable |
| state_out | output | 64 | New loop-state word |
| gpr_we | output | 1 | Register write enable |
| gpr_num | output | 5 | Register to write |
| gpr_data | output | 64 | Zero-extended VL |
| cr_we | output | 1 | Condition nibble write enable |
| cr0 | output | 4 | Condition nibble {LT,GT,EQ,SO} |

## Verification
The assertions check on every cycle the properties that hold for every result. The written VL never exceeds the written MVL. The register write targets a nonzero register and carries exactly the VL in the new state word. EQ and GT are never set together and LT is never set. The mode bits hold when no new maximum length was requested. Enables follow `in_valid` by one cycle. Only the bench's scenarios can show that the right source wins the field-number priority, the wrap of the immediate at 127, saturation against clamping when both occur, and the exact overflow flag, since each depends on specific operand values.

// File: rtl/vlen_pkg.sv
package vlen_pkg;

    localparam int unsigned XLEN_D  = 64;
    localparam int unsigned LEN_W_D = 7;
    localparam int unsigned REG_AW_D = 5;

    // big-endian field positions of the loop-state word
    localparam int unsigned POS_MVL   = 0;
    localparam int unsigned POS_VF    = 63;
    localparam int unsigned POS_PERST = 62;

    // condition nibble bit indices
    localparam int unsigned CR_LT = 3;
    localparam int unsigned CR_GT = 2;
    localparam int unsigned CR_EQ = 1;
    localparam int unsigned CR_SO = 0;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } vls_state_t;

    // the single place that converts big-endian positions to vector indices
    function automatic int unsigned be_idx(input int unsigned xlen, input int unsigned pos);
        return xlen - 1 - pos;
    endfunction

endpackage

// File: rtl/vlen_src_sel.sv
module vlen_src_sel #(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned LEN_W  = 7,
    parameter int unsigned REG_AW = 5
) (
    input  logic [LEN_W-1:0]  imm_inc,
    input  logic [LEN_W-1:0]  cur_vl,
    input  logic              set_vl,
    input  logic [REG_AW-1:0] ra_num,
    input  logic [REG_AW-1:0] rt_num,
    input  logic [XLEN-1:0]   ra_val,
    input  logic [XLEN-1:0]   ctr_val,
    output logic [LEN_W-1:0]  vl_pick,
    output logic              sat_ovf
);
    localparam logic [XLEN-1:0] LIMIT = {{(XLEN-LEN_W){1'b0}}, {LEN_W{1'b1}}};

    logic [XLEN-1:0] reg_src;
    logic            ra_zero;
    logic            rt_zero;

    assign ra_zero = (ra_num == '0);
    assign rt_zero = (rt_num == '0);
    assign reg_src = ra_zero ? ctr_val : ra_val;

    always_comb begin
        vl_pick = cur_vl;
        sat_ovf = 1'b0;
        if (set_vl) begin
            if (ra_zero && rt_zero) begin
                vl_pick = imm_inc;
            end else if (reg_src > LIMIT) begin
                vl_pick = {LEN_W{1'b1}};
                sat_ovf = 1'b1;
            end else begin
                vl_pick = reg_src[LEN_W-1:0];
            end
        end
    end
endmodule

// File: rtl/vlen_clamp.sv
module vlen_clamp #(
    parameter int unsigned LEN_W = 7
) (
    input  logic [LEN_W-1:0] vl_in,
    input  logic [LEN_W-1:0] mvl,
    output logic [LEN_W-1:0] vl_out,
    output logic             clamp_ovf
);
    always_comb begin
        clamp_ovf = (vl_in > mvl);
        vl_out    = clamp_ovf ? mvl : vl_in;
    end
endmodule

// File: rtl/vlen_cr_pack.sv
module vlen_cr_pack #(
    parameter int unsigned LEN_W = 7
) (
    input  logic [LEN_W-1:0] vl,
    input  logic             ovf,
    output logic [3:0]       nibble
);
    import vlen_pkg::*;

    always_comb begin
        nibble        = '0;
        nibble[CR_GT] = (vl != '0);
        nibble[CR_EQ] = (vl == '0);
        nibble[CR_SO] = ovf;
    end
endmodule

// File: rtl/vlen_set_unit.sv
module vlen_set_unit
    import vlen_pkg::*;
#(
    parameter int unsigned XLEN   = XLEN_D,
    parameter int unsigned LEN_W  = LEN_W_D,
    parameter int unsigned REG_AW = REG_AW_D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [LEN_W-1:0]  imm,
    input  logic              set_mvl,
    input  logic              set_vl,
    input  logic              vf_bit,
    input  logic [REG_AW-1:0] ra_num,
    input  logic [REG_AW-1:0] rt_num,
    input  logic              rc,
    input  logic [XLEN-1:0]   ra_val,
    input  logic [XLEN-1:0]   ctr_val,
    input  logic [XLEN-1:0]   state_in,
    output logic              state_we,
    output logic [XLEN-1:0]   state_out,
    output logic              gpr_we,
    output logic [REG_AW-1:0] gpr_num,
    output logic [XLEN-1:0]   gpr_data,
    output logic              cr_we,
    output logic [3:0]        cr0
);
    localparam int unsigned MVL_HI = be_idx(XLEN, POS_MVL);
    localparam int unsigned MVL_LO = be_idx(XLEN, POS_MVL + LEN_W - 1);
    localparam int unsigned VL_HI  = be_idx(XLEN, POS_MVL + LEN_W);
    localparam int unsigned VL_LO  = be_idx(XLEN, POS_MVL + 2*LEN_W - 1);
    localparam int unsigned VF_IX  = be_idx(XLEN, POS_VF);
    localparam int unsigned PST_IX = be_idx(XLEN, POS_PERST);

    // ---------------- datapath ----------------
    logic [LEN_W-1:0] imm_inc;
    logic [LEN_W-1:0] cur_mvl;
    logic [LEN_W-1:0] cur_vl;
    logic [LEN_W-1:0] new_mvl;
    logic [LEN_W-1:0] vl_pick;
    logic [LEN_W-1:0] vl_final;
    logic             sat_ovf;
    logic             clamp_ovf;
    logic [3:0]       cr_nib;
    logic [XLEN-1:0]  state_nxt;

    assign imm_inc = imm + LEN_W'(1);
    assign cur_mvl = state_in[MVL_HI:MVL_LO];
    assign cur_vl  = state_in[VL_HI:VL_LO];
    assign new_mvl = set_mvl ? imm_inc : cur_mvl;

    vlen_src_sel #(
        .XLEN   (XLEN),
        .LEN_W  (LEN_W),
        .REG_AW (REG_AW)
    ) u_src_sel (
        .imm_inc (imm_inc),
        .cur_vl  (cur_vl),
        .set_vl  (set_vl),
        .ra_num  (ra_num),
        .rt_num  (rt_num),
        .ra_val  (ra_val),
        .ctr_val (ctr_val),
        .vl_pick (vl_pick),
        .sat_ovf (sat_ovf)
    );

    vlen_clamp #(
        .LEN_W (LEN_W)
    ) u_clamp (
        .vl_in     (vl_pick),
        .mvl       (new_mvl),
        .vl_out    (vl_final),
        .clamp_ovf (clamp_ovf)
    );

    vlen_cr_pack #(
        .LEN_W (LEN_W)
    ) u_cr_pack (
        .vl     (vl_final),
        .ovf    (sat_ovf | clamp_ovf),
        .nibble (cr_nib)
    );

    always_comb begin
        state_nxt                = state_in;
        state_nxt[MVL_HI:MVL_LO] = new_mvl;
        state_nxt[VL_HI:VL_LO]   = vl_final;
        if (set_mvl) begin
            state_nxt[VF_IX]  = vf_bit;
            state_nxt[PST_IX] = 1'b0;
        end
    end

    // ---------------- state register ----------------
    vls_state_t fsm_q;
    vls_state_t fsm_d;

    always_comb begin
        unique case (fsm_q)
            ST_IDLE: fsm_d = in_valid ? ST_RESP : ST_IDLE;  // accept
            ST_RESP: fsm_d = in_valid ? ST_RESP : ST_IDLE;  // chain / retire
            default: fsm_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fsm_q <= ST_IDLE;
        else        fsm_q <= fsm_d;
    end

    // ---------------- result capture ----------------
    logic [XLEN-1:0]   state_r;
    logic [REG_AW-1:0] gnum_r;
    logic [LEN_W-1:0]  vl_r;
    logic [3:0]        cr_r;
    logic              gflag_r;
    logic              cflag_r;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_r <= '0;
            gnum_r  <= '0;
            vl_r    <= '0;
            cr_r    <= '0;
            gflag_r <= 1'b0;
            cflag_r <= 1'b0;
        end else if (in_valid) begin
            state_r <= state_nxt;
            gnum_r  <= rt_num;
            vl_r    <= vl_final;
            cr_r    <= cr_nib;
            gflag_r <= (rt_num != '0);
            cflag_r <= rc;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        state_we = 1'b0;
        gpr_we   = 1'b0;
        cr_we    = 1'b0;
        unique case (fsm_q)
            ST_IDLE: begin
                state_we = 1'b0;
            end
            ST_RESP: begin
                state_we = 1'b1;
                gpr_we   = gflag_r;
                cr_we    = cflag_r;
            end
            default: begin
                state_we = 1'b0;
            end
        endcase
    end

    assign state_out = state_r;
    assign gpr_num   = gnum_r;
    assign gpr_data  = {{(XLEN-LEN_W){1'b0}}, vl_r};
    assign cr0       = cr_r;

    // ---------------- assertions ----------------
    a_r5_vl_within_mvl: assert property (@(posedge clk) disable iff (!rst_n)
        state_we |-> (state_out[VL_HI:VL_LO] <= state_out[MVL_HI:MVL_LO]));

    a_r6_gpr_nonzero_rt: assert property (@(posedge clk) disable iff (!rst_n)
        gpr_we |-> (gpr_num != '0));

    a_r6_gpr_data_vl: assert property (@(posedge clk) disable iff (!rst_n)
        gpr_we |-> (gpr_data == {{(XLEN-LEN_W){1'b0}}, state_out[VL_HI:VL_LO]}));

    a_r8_cr_eq_gt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we |-> ((cr0[CR_EQ] != cr0[CR_GT]) && !cr0[CR_LT]));

    a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_we && !$past(set_mvl)) |->
            (state_out[VF_IX] == $past(state_in[VF_IX]) &&
             state_out[PST_IX] == $past(state_in[PST_IX])));

    a_r10_we_follows_valid: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> state_we);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!state_we && !gpr_we && !cr_we));
endmodule

// File: tb/vlen_set_unit_bench.sv
`timescale 1ns/1ps
module vlen_set_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [6:0]  imm = '0;
    logic        set_mvl = 1'b0;
    logic        set_vl = 1'b0;
    logic        vf_bit = 1'b0;
    logic [4:0]  ra_num = '0;
    logic [4:0]  rt_num = '0;
    logic        rc = 1'b0;
    logic [63:0] ra_val = '0;
    logic [63:0] ctr_val = '0;
    logic [63:0] state_in = '0;
    logic        state_we;
    logic [63:0] state_out;
    logic        gpr_we;
    logic [4:0]  gpr_num;
    logic [63:0] gpr_data;
    logic        cr_we;
    logic [3:0]  cr0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vlen_set_unit u_vlen_set_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .imm(imm),
        .set_mvl(set_mvl), .set_vl(set_vl), .vf_bit(vf_bit),
        .ra_num(ra_num), .rt_num(rt_num), .rc(rc), .ra_val(ra_val),
        .ctr_val(ctr_val), .state_in(state_in), .state_we(state_we),
        .state_out(state_out), .gpr_we(gpr_we), .gpr_num(gpr_num),
        .gpr_data(gpr_data), .cr_we(cr_we), .cr0(cr0)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // expected results from the requirements
    task automatic model(input logic [6:0] i_imm, input bit ms, input bit vs,
                         input bit vf, input logic [4:0] ra, input logic [4:0] rt,
                         input logic [63:0] rav, input logic [63:0] ctr,
                         input logic [63:0] st,
                         output logic [63:0] st_o, output logic [6:0] vl_o,
                         output logic [3:0] cr_o);
        logic [6:0]  inc;
        logic [6:0]  mvl;
        logic [6:0]  vl;
        logic [63:0] src;
        bit          ovf;
        inc = i_imm + 7'd1;                          // R1
        mvl = ms ? inc : st[63:57];
        ovf = 1'b0;
        src = '0;
        if (!vs) vl = st[56:50];                     // R2
        else if (ra == 5'd0 && rt == 5'd0) vl = inc; // R3
        else begin
            src = (ra != 5'd0) ? rav : ctr;
            if (src > 64'd127) begin vl = 7'd127; ovf = 1'b1; end  // R4
            else vl = src[6:0];
        end
        if (vl > mvl) begin vl = mvl; ovf = 1'b1; end             // R5
        st_o = st;                                    // R9
        st_o[63:57] = mvl;
        st_o[56:50] = vl;
        if (ms) begin st_o[0] = vf; st_o[1] = 1'b0; end           // R7
        vl_o = vl;
        cr_o = {1'b0, vl != 7'd0, vl == 7'd0, ovf};  // R8
    endtask

    task automatic txn(input logic [6:0] i_imm, input bit ms, input bit vs,
                       input bit vf, input logic [4:0] ra, input logic [4:0] rt,
                       input bit i_rc, input logic [63:0] rav,
                       input logic [63:0] ctr, input logic [63:0] st);
        logic [63:0] e_st;
        logic [6:0]  e_vl;
        logic [3:0]  e_cr;
        @(negedge clk);
        chk(!state_we && !gpr_we && !cr_we, "R10", "enables idle",
            {61'd0, state_we, gpr_we, cr_we}, 64'd0);
        imm = i_imm; set_mvl = ms; set_vl = vs; vf_bit = vf;
        ra_num = ra; rt_num = rt; rc = i_rc; ra_val = rav;
        ctr_val = ctr; state_in = st; in_valid = 1'b1;
        model(i_imm, ms, vs, vf, ra, rt, rav, ctr, st, e_st, e_vl, e_cr);
        @(negedge clk);
        in_valid = 1'b0;
        chk(state_we == 1'b1, "R10", "state_we", {63'd0, state_we}, 64'd1);
        chk(state_out[63:50] == e_st[63:50], "R1 R3 R5", "mvl/vl fields",
            {50'd0, state_out[63:50]}, {50'd0, e_st[63:50]});
        chk(state_out == e_st, "R7 R9", "state word", state_out, e_st);
        chk(gpr_we == (rt != 5'd0), "R6", "gpr_we", {63'd0, gpr_we},
            {63'd0, rt != 5'd0});
        if (rt != 5'd0) begin
            chk(gpr_num == rt && gpr_data == {57'd0, e_vl}, "R6", "gpr write",
                {gpr_num, gpr_data[58:0]}, {rt, 52'd0, e_vl});
        end
        chk(cr_we == i_rc, "R8", "cr_we", {63'd0, cr_we}, {63'd0, i_rc});
        if (i_rc) begin
            chk(cr0 == e_cr, "R4 R5 R8", "cr0", {60'd0, cr0}, {60'd0, e_cr});
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        chk(!state_we && !gpr_we && !cr_we && state_out == 64'd0, "R10",
            "reset outputs", state_out, 64'd0);
        rst_n = 1'b1;

        // R1: immediate 7 -> MVL 8, VL from immediate path
        txn(7'd7, 1, 1, 1, 5'd0, 5'd0, 1, 64'd0, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        // R1: immediate 127 wraps to MVL 0, VL clamps to 0 (R5)
        txn(7'd127, 1, 1, 0, 5'd0, 5'd0, 1, 64'd0, 64'd0, 64'h0123_4567_89AB_CDEF);
        // R3/R4: RA huge saturates, clamp at MVL 64 also raises overflow
        txn(7'd63, 1, 1, 1, 5'd3, 5'd4, 1, 64'h1_0000_0000, 64'd5, 64'd0);
        // R4: CTR 128 saturates to 127 under MVL 128->0? use MVL 127
        txn(7'd126, 1, 1, 0, 5'd0, 5'd9, 1, 64'd9, 64'd128, 64'd2);
        // R3: CTR 127 exactly, no saturation
        txn(7'd126, 1, 1, 0, 5'd0, 5'd9, 1, 64'd9, 64'd127, 64'd0);
        // R3: RA nonzero with RT zero uses RA value
        txn(7'd0, 0, 1, 1, 5'd7, 5'd0, 1, 64'd20, 64'd3, {7'd100, 7'd1, 50'h3});
        // R2/R5: VL held but above held MVL -> clamp, mode bits kept (R7)
        txn(7'd0, 0, 0, 1, 5'd0, 5'd5, 1, 64'd0, 64'd0, {7'd10, 7'd30, 50'h2});
        // R2: hold within range, no overflow, getvl-like
        txn(7'd0, 0, 0, 0, 5'd0, 5'd6, 1, 64'd0, 64'd0, {7'd40, 7'd12, 50'h1});
        // R8: zero VL from RA value 0
        txn(7'd15, 1, 1, 0, 5'd2, 5'd0, 1, 64'd0, 64'd99, 64'd3);

        for (int n = 0; n < 400; n++) begin
            logic [63:0] rv;
            logic [63:0] cv;
            rv = ($urandom % 2) ? {56'd0, 8'($urandom)} : {$urandom, $urandom};
            cv = ($urandom % 2) ? {56'd0, 8'($urandom)} : {$urandom, $urandom};
            txn(7'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                ($urandom % 3 == 0) ? 5'd0 : 5'($urandom),
                ($urandom % 3 == 0) ? 5'd0 : 5'($urandom),
                1'($urandom), rv, cv, {$urandom, $urandom});
        end

        @(negedge clk);
        chk(!state_we && !gpr_we && !cr_we, "R10", "final idle",
            {61'd0, state_we, gpr_we, cr_we}, 64'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule